// File: doc/BRIEF.md
# Three-Bank Clock Divider with Synchronized Start and Ordered Stop

The block takes one fast input clock and produces eight clock outputs grouped into three banks: bank A with four outputs, bank B with three and bank C with one. Every bank has a divide-select input. Bank A can pass the input clock straight through or halve it. Banks B and C can halve it or quarter it. All the outputs of one bank carry the same waveform.

An active-low reset forces every output low at once, with no clock needed. An output-enable input, brought into the clock domain by a two-stage synchronizer, sets when the outputs run. After a start, every output rises on the same input edge. After a stop request, the outputs wind down slowest first, so that no output makes a pulse shorter than half of its own period. All divided outputs come from one shared phase counter, so every rising edge is aligned with a rising edge of the input clock. The pass-through path uses a clock gate that only changes state while the input clock is low. A new divide select takes effect only on a four-cycle phase boundary.

Top module: `multi_bank_clkdiv`

## Requirements
- R1: Bank A follows the input clock (divide by 1) when `selA` is 0, and divides it by 2 when `selA` is 1. All bank A outputs are identical.
- R2: Banks B and C each divide the input clock by 2 when their select is 0 and by 4 when it is 1. A divide-by-2 output is high for one input cycle and then low for one. A divide-by-4 output is high for two cycles and then low for two. Each divided output is high in the first part of its period.
- R3: While `rstN` is 0, every output is 0, and this applies immediately, without a clock edge.
- R4: When `rstN` is released with `en` held at 1, all eight outputs stay 0 through the first three rising edges. All of them go high together at the fourth rising edge after the release.
- R5: While the synchronized enable is 0, every output stays 0. When `en` rises between two clock edges, all outputs go high together at the fourth rising edge that follows.
- R6: After `en` falls, the divide-by-4 outputs end their last high phase no later than the divide-by-2 outputs. The divide-by-2 outputs end theirs strictly before the divide-by-1 outputs. All outputs are low within six input cycles of the fall.
- R7: A change on any select input takes effect only at a rising edge that starts a new four-cycle phase, or while the outputs are stopped. Until then, the bank keeps its previous ratio.
- R8: While running, the shared phase counter advances by one on every rising edge. It starts from phase 0 on the edge where the outputs first rise, so no divided output makes a runt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| en | input | 1 | Output enable, asynchronous to clk |
| selA | input | 1 | Bank A ratio: 0 gives divide by 1, 1 gives divide by 2 |
| selB | input | 1 | Bank B ratio: 0 gives divide by 2, 1 gives divide by 4 |
| selC | input | 1 | Bank C ratio: 0 gives divide by 2, 1 gives divide by 4 |
| qA | output | NUM_A (4) | Bank A clock outputs |
| qB | output | NUM_B (3) | Bank B clock outputs |
| qC | output | NUM_C (1) | Bank C clock output |

## Verification
The bench builds the block with its default parameters: four, three and one outputs per bank, and a two-stage enable synchronizer. This fixes the start latency at four edges and the stop sequence within six cycles, so those latencies can be checked to the exact edge. The outputs are sampled in both the high and the low half of each input cycle. This makes the pass-through bank-A waveform and its late stop visible next to the divided banks. Random toggling of the enable, the selects and occasional resets reaches select changes at every phase of the four-cycle window and stop requests at every counter phase.

// File: rtl/clkdiv_bank_pkg.sv
package clkdiv_bank_pkg;

  localparam int PHASE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_DRAIN
  } runState_t;

  typedef struct packed {
    logic count;     // phase counter advances
    logic gate4;     // quarter-rate outputs may be high
    logic gate2;     // half-rate outputs may be high
    logic gate1Req;  // request to the low-phase clock gate
  } gateStrobes_t;

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic         phaseZero,
  output gateStrobes_t ctlBus
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   enSeen;
  runState_t              state;
  runState_t              stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_TOP-1:0], en};
  end

  assign enSeen = syncQ[SYNC_TOP];

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (enSeen) stateNext = ST_ARM;
      ST_ARM:   stateNext = ST_RUN;
      ST_RUN:   if (!enSeen && !phaseZero) stateNext = ST_DRAIN;
      ST_DRAIN: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctlBus.count    = (state == ST_RUN) || (state == ST_DRAIN);
    ctlBus.gate4    = (state == ST_RUN);
    ctlBus.gate2    = (state == ST_RUN) || (state == ST_DRAIN);
    ctlBus.gate1Req = (state != ST_IDLE);
  end

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_bank_pkg::*;
#(
  parameter int NUM_A = 4,
  parameter int NUM_B = 3,
  parameter int NUM_C = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selA,
  input  logic               selB,
  input  logic               selC,
  input  gateStrobes_t       ctlBus,
  output logic [PHASE_W-1:0] phase,
  output logic [2:0]         selEff,
  output logic [NUM_A-1:0]   qA,
  output logic [NUM_B-1:0]   qB,
  output logic [NUM_C-1:0]   qC
);

  localparam logic [PHASE_W-1:0] PHASE_LAST = '1;

  logic selLoad;
  logic gate1;
  logic fastClk;
  logic halfClk;
  logic quarterClk;
  logic bankA;
  logic bankB;
  logic bankC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phase <= '0;
    else if (ctlBus.count) phase <= phase + 1'b1;
    else                   phase <= '0;
  end

  assign selLoad = !ctlBus.count || (phase == PHASE_LAST);

  // bit 0: bank A, bit 1: bank B, bit 2: bank C
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        selEff <= 3'b111;
    else if (selLoad) selEff <= {selC, selB, selA};
  end

  // gate opens or closes only while the input clock is low
  always_latch begin
    if (!rstN)    gate1 = 1'b0;
    else if (!clk) gate1 = ctlBus.gate1Req;
  end

  assign fastClk    = clk & gate1;
  assign halfClk    = ctlBus.gate2 & ~phase[0];
  assign quarterClk = ctlBus.gate4 & ~phase[1];

  assign bankA = selEff[0] ? halfClk    : fastClk;
  assign bankB = selEff[1] ? quarterClk : halfClk;
  assign bankC = selEff[2] ? quarterClk : halfClk;

  for (genvar i = 0; i < NUM_A; i++) begin : g_bankA
    assign qA[i] = bankA;
  end
  for (genvar i = 0; i < NUM_B; i++) begin : g_bankB
    assign qB[i] = bankB;
  end
  for (genvar i = 0; i < NUM_C; i++) begin : g_bankC
    assign qC[i] = bankC;
  end

endmodule

// File: rtl/multi_bank_clkdiv.sv
module multi_bank_clkdiv
  import clkdiv_bank_pkg::*;
#(
  parameter int NUM_A       = 4,
  parameter int NUM_B       = 3,
  parameter int NUM_C       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             selA,
  input  logic             selB,
  input  logic             selC,
  output logic [NUM_A-1:0] qA,
  output logic [NUM_B-1:0] qB,
  output logic [NUM_C-1:0] qC
);

  gateStrobes_t       ctlBus;
  logic [PHASE_W-1:0] phase;
  logic [2:0]         selEff;
  logic               phaseZero;

  assign phaseZero = (phase == '0);

  clkdiv_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .en       (en),
    .phaseZero(phaseZero),
    .ctlBus   (ctlBus)
  );

  clkdiv_datapath #(
    .NUM_A(NUM_A),
    .NUM_B(NUM_B),
    .NUM_C(NUM_C)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .selA  (selA),
    .selB  (selB),
    .selC  (selC),
    .ctlBus(ctlBus),
    .phase (phase),
    .selEff(selEff),
    .qA    (qA),
    .qB    (qB),
    .qC    (qC)
  );

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
  import clkdiv_bank_pkg::*;
#(
  parameter int NUM_A = 4,
  parameter int NUM_B = 3,
  parameter int NUM_C = 1
) (
  input logic               clk,
  input logic               rstN,
  input gateStrobes_t       ctlBus,
  input logic [PHASE_W-1:0] phase,
  input logic [2:0]         selEff,
  input logic [NUM_A-1:0]   qA,
  input logic [NUM_B-1:0]   qB,
  input logic [NUM_C-1:0]   qC
);

  a_r3_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (qA == '0 && qB == '0 && qC == '0));

  a_r6_quarter_before_half: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.gate4 |-> ctlBus.gate2);

  a_r6_half_before_fast: assert property (@(posedge clk) disable iff (!rstN)
    ctlBus.gate2 |-> ctlBus.gate1Req);

  a_r4_start_phase_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlBus.gate4) |-> phase == '0);

  a_r8_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlBus.count) |-> phase == $past(phase) + 1'b1);

  a_r7_sel_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (selEff != $past(selEff)) |-> phase == '0);

endmodule

bind multi_bank_clkdiv clkdiv_checker #(
  .NUM_A(NUM_A),
  .NUM_B(NUM_B),
  .NUM_C(NUM_C)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .ctlBus(ctlBus),
  .phase (phase),
  .selEff(selEff),
  .qA    (qA),
  .qB    (qB),
  .qC    (qC)
);

// File: tb/tb_multi_bank_clkdiv.sv
module tb_multi_bank_clkdiv;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       en   = 1'b1;
  logic       selA = 1'b0;
  logic       selB = 1'b0;
  logic       selC = 1'b1;
  logic [3:0] qA;
  logic [2:0] qB;
  logic [0:0] qC;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  multi_bank_clkdiv dut (
    .clk(clk), .rstN(rstN), .en(en),
    .selA(selA), .selB(selB), .selC(selC),
    .qA(qA), .qB(qB), .qC(qC)
  );

  // requirement-level reference timeline
  logic [1:0] mSync = 2'b00;
  int         mSt   = 0;   // 0 stopped, 1 armed, 2 running, 3 draining
  logic [1:0] mK    = 2'b00;
  logic       mSA = 1'b1, mSB = 1'b1, mSC = 1'b1;
  logic       mG1 = 1'b0;

  always @(posedge clk or negedge rstN) begin : model_edge
    int nxt;
    logic counting;
    if (!rstN) begin
      mSync = 2'b00; mSt = 0; mK = 2'b00;
      mSA = 1'b1; mSB = 1'b1; mSC = 1'b1;
    end else begin
      counting = (mSt >= 2);
      nxt = mSt;
      if (mSt == 0 && mSync[1]) nxt = 1;
      else if (mSt == 1) nxt = 2;
      else if (mSt == 2 && !mSync[1] && mK != 2'd0) nxt = 3;
      else if (mSt == 3) nxt = 0;
      if (!counting || mK == 2'd3) begin
        mSA = selA; mSB = selB; mSC = selC;
      end
      mK    = counting ? mK + 2'd1 : 2'd0;
      mSync = {mSync[0], en};
      mSt   = nxt;
    end
  end

  always @(negedge clk or negedge rstN) begin
    if (!rstN) mG1 = 1'b0;
    else       mG1 = (mSt != 0);
  end

  task automatic expOuts(input bit hiPhase, output logic [3:0] eA,
                         output logic [2:0] eB, output logic eC);
    logic d1, d2, d4;
    d1 = hiPhase & mG1 & rstN;
    d2 = (mSt >= 2) & ~mK[0];
    d4 = (mSt == 2) & ~mK[1];
    eA = {4{mSA ? d2 : d1}};
    eB = {3{mSB ? d4 : d2}};
    eC = mSC ? d4 : d2;
  endtask

  task automatic cmpModel(input bit hiPhase);
    logic [3:0] eA; logic [2:0] eB; logic eC;
    expOuts(hiPhase, eA, eB, eC);
    vecs++;
    if (qA !== eA) begin
      errs++; $display("FAIL R1 bank A actual=%b expected=%b t=%0t", qA, eA, $time);
    end else if ({qB, qC} !== {eB, eC}) begin
      errs++; $display("FAIL R2 banks B/C actual=%b_%b expected=%b_%b t=%0t", qB, qC, eB, eC, $time);
    end
  endtask

  always begin
    @(posedge clk); #1; if (!done) cmpModel(1'b1);
    @(negedge clk); #1; if (!done) cmpModel(1'b0);
  end

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {qA, qB, qC};
    vecs++;
    if (act !== exp) begin
      errs++; $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic stepHi();
    @(posedge clk); #1.25;
  endtask
  task automatic stepLo();
    @(negedge clk); #1.25;
  endtask

  function automatic logic [7:0] allOf(input bit a, input bit b, input bit c);
    return {{4{a}}, {3{b}}, c};
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    int lastA, lastB, lastC;
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(posedge clk);
    #1.25;
    chk("R3 held in reset", 8'h00);

    // R4: release with enable high, A /1, B /2, C /4
    rstN = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      stepHi(); chk("R4 quiet before fourth edge", 8'h00);
    end
    stepHi(); chk("R4 all rise on fourth edge", 8'hFF);
    stepLo(); chk("R1 divide-by-1 low half", allOf(0, 1, 1));
    for (int k = 1; k <= 7; k++) begin
      stepHi();
      chk("R2 R8 ratios per cycle", allOf(1, (k % 2) == 0, (k % 4) < 2));
    end

    // R6: stop order after enable falls
    en = 1'b0;
    lastA = -1; lastB = -1; lastC = -1;
    for (int h = 0; h < 16; h++) begin
      if (h % 2 == 0) stepHi(); else stepLo();
      if (qA[0]) lastA = h;
      if (qB[0]) lastB = h;
      if (qC[0]) lastC = h;
    end
    vecs++;
    if (!(lastC <= lastB && lastB < lastA)) begin
      errs++; $display("FAIL R6 order actual=C%0d B%0d A%0d expected=C<=B<A", lastC, lastB, lastA);
    end
    vecs++;
    if (lastA >= 12) begin
      errs++; $display("FAIL R6 latency actual=%0d expected=<12 half cycles", lastA);
    end
    chk("R6 all low after stop", 8'h00);

    // R5: held low while disabled, then restart with A /2
    selA = 1'b1;
    repeat (3) begin stepHi(); chk("R5 low while disabled", 8'h00); end
    en = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      stepHi(); chk("R5 quiet before fourth edge", 8'h00);
    end
    stepHi(); chk("R5 all rise together", 8'hFF);
    stepLo(); chk("R1 divide-by-2 holds high", 8'hFF);

    // R7: bank B /2 -> /4 requested mid-window
    stepHi(); chk("R7 k1", allOf(0, 0, 1));
    selB = 1'b1;
    stepHi(); chk("R7 old ratio kept at k2", allOf(1, 1, 0));
    stepHi(); chk("R7 k3", allOf(0, 0, 0));
    stepHi(); chk("R7 k4 boundary", allOf(1, 1, 1));
    stepHi(); chk("R7 new ratio at k5", allOf(0, 1, 1));
    stepHi();
    rstN = 1'b0;
    #0.5 chk("R3 immediate reset", 8'h00);
    stepHi(); chk("R3 reset held", 8'h00);
    rstN = 1'b1;

    // random phase, checked against the reference timeline
    for (int c = 0; c < 4000; c++) begin
      stepHi();
      if ($urandom_range(39) == 0) en = ~en;
      if ($urandom_range(11) == 0) selA = $urandom_range(1);
      if ($urandom_range(11) == 0) selB = $urandom_range(1);
      if ($urandom_range(11) == 0) selC = $urandom_range(1);
      if (!rstN) rstN = 1'b1;
      else if ($urandom_range(499) == 0) rstN = 1'b0;
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule